// File: doc/BRIEF.md
# Redundant-Core Signature Checkpoint Controller

This block sits beside a pair of cores that execute the same program redundantly. Each core reports every retired instruction result, and the block folds each core's results into that core's own 16-bit running signature. Nothing is compared at retirement. A comparison is made only when something outside the protected boundary is about to observe results: a writeback to memory, handing modified data to another processor, or a device access. The party that wants to let such an event proceed raises a visibility request and holds it until the block grants it.

When a request arrives and both cores have retired the same number of results since the last recovery point, the two signatures are compared in that cycle. If they agree, the request is granted and a new recovery point is committed. The current architectural register values are copied into a snapshot store that holds one checkpoint only, and both signatures restart. If they disagree, the block pulses a rollback and then plays the held snapshot out on a restore port, one register per cycle. The checkpoint itself is left as it was, so a later error can recover to the same point again.

Top module: `fp_ckpt_ctrl`

## Requirements
- R1: Each core's signature starts at 0xFFFF. Each retired 32-bit result is folded in as a CRC with polynomial 0x1021, most significant data bit first. The signature therefore depends on both the values and their order: two cores that retire the same words in a different order do not match.
- R2: While a request is raised and the two cores' retirement counts since the last recovery point differ, grant, commit and rollback all stay low, and retirements keep being counted.
- R3: When a request is raised, no restore is running, and the counts and signatures are both equal, grant and the commit pulse are high in that same cycle.
- R4: A commit copies the register input into the snapshot store at the commit edge. Register i is bits [32*i+31 : 32*i] of the flat input.
- R5: When a request is raised, no restore is running, the counts are equal and the signatures differ, the rollback pulse is high and grant stays low in that same cycle.
- R6: Starting in the cycle after a rollback pulse, the restore port is valid for exactly 8 consecutive cycles. The index goes 0 to 7 in ascending order and the data is the snapshot word with that index. Valid then falls.
- R7: A rollback does not change the snapshot, so two rollbacks with no commit between them restore identical data.
- R8: After a commit or a rollback, both signatures restart at the seed and both counts at zero, so only results retired afterwards take part in the next comparison.
- R9: During the rollback cycle and the whole restore sequence, retirements are discarded and requests get no grant, commit or rollback.
- R10: A result retired in the same cycle as a commit belongs to the new interval and is folded into the freshly seeded signature.
- R11: After reset, grant, commit, rollback and restore valid are low and every snapshot word is zero.
- R12: Commit and rollback are never high together, and grant is never high without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_a_valid | input | 1 | Core A retires a result this cycle |
| core_a_result | input | 32 | Core A retired result |
| core_b_valid | input | 1 | Core B retires a result this cycle |
| core_b_result | input | 32 | Core B retired result |
| arch_regs | input | 256 | Current architectural registers, register i in bits [32i+31:32i] |
| vis_req | input | 1 | An externally visible event is waiting |
| vis_grant | output | 1 | The event may proceed (signatures matched) |
| commit_pulse | output | 1 | A new recovery point is taken at this edge |
| rollback_pulse | output | 1 | Signatures differ; recover to the held point |
| restore_valid | output | 1 | Restore port carries a snapshot word |
| restore_idx | output | 3 | Register index on the restore port |
| restore_data | output | 32 | Snapshot word for restore_idx |

## Verification
The bound checker watches, on every cycle, that commit and rollback never coincide and that grant never appears without a request. It also checks the shape of the restore burst: it starts at index 0 right after a rollback, steps by one and ends after index 7, and no grant or rollback happens while it runs. Only the bench scenarios can show the data-dependent part. This covers whether the signatures really separate different or reordered streams, whether the snapshot holds the registers of the right commit and survives repeated rollbacks, and whether retirements in the commit cycle, the rollback cycle and during a restore are counted or discarded as required.

// File: rtl/fp_ckpt_pkg.sv
package fp_ckpt_pkg;

    parameter int DATA_W = 32;
    parameter int SIG_W  = 16;
    parameter int CNT_W  = 16;
    parameter int NREG   = 8;
    parameter int NCORE  = 2;

    parameter logic [SIG_W-1:0] CRC_POLY = 16'h1021;
    parameter logic [SIG_W-1:0] CRC_SEED = 16'hFFFF;

    typedef struct packed {
        logic [SIG_W-1:0] sig;
        logic [CNT_W-1:0] cnt;
    } sig_state_t;

    typedef enum logic {
        SNAP_IDLE    = 1'b0,
        SNAP_RESTORE = 1'b1
    } snap_mode_t;

    // One retired word folded into a signature, msb of the word first.
    function automatic logic [SIG_W-1:0] crc_fold(input logic [SIG_W-1:0] s,
                                                   input logic [DATA_W-1:0] d);
        logic [SIG_W-1:0] c;
        logic             fb;
        c = s;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = c[SIG_W-1] ^ d[i];
            c  = {c[SIG_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/fp_sig_unit.sv
module fp_sig_unit
    import fp_ckpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ret_valid,
    input  logic [DATA_W-1:0] ret_data,
    input  logic              restart,
    input  logic              discard,
    output sig_state_t        state
);

    sig_state_t cur;
    sig_state_t base;

    // A restart (commit) seeds the interval; a same-cycle retirement joins it.
    always_comb begin
        if (restart) begin
            base.sig = CRC_SEED;
            base.cnt = '0;
        end else begin
            base = cur;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || discard) begin
            cur.sig <= CRC_SEED;
            cur.cnt <= '0;
        end else if (ret_valid) begin
            cur.sig <= crc_fold(base.sig, ret_data);
            cur.cnt <= base.cnt + 1'b1;
        end else begin
            cur <= base;
        end
    end

    assign state = cur;

endmodule

// File: rtl/fp_snap_store.sv
module fp_snap_store
    import fp_ckpt_pkg::*;
#(
    parameter  int NR    = NREG,
    localparam int IDX_W = $clog2(NR)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 capture,
    input  logic [NR*DATA_W-1:0] regs_in,
    input  logic                 start,
    output logic                 busy,
    output logic [IDX_W-1:0]     idx,
    output logic [DATA_W-1:0]    data
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NR - 1);

    logic [DATA_W-1:0] snap [NR];
    snap_mode_t        mode;
    logic [IDX_W-1:0]  ptr;

    for (genvar g = 0; g < NR; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)          snap[g] <= '0;
            else if (capture) snap[g] <= regs_in[g*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= SNAP_IDLE;
            ptr  <= '0;
        end else if (start) begin
            mode <= SNAP_RESTORE;
            ptr  <= '0;
        end else if (mode == SNAP_RESTORE) begin
            if (ptr == LAST) begin
                mode <= SNAP_IDLE;
                ptr  <= '0;
            end else begin
                ptr <= ptr + 1'b1;
            end
        end
    end

    assign busy = (mode == SNAP_RESTORE);
    assign idx  = ptr;
    assign data = busy ? snap[ptr] : '0;

endmodule

// File: rtl/fp_ckpt_ctrl.sv
module fp_ckpt_ctrl
    import fp_ckpt_pkg::*;
#(
    parameter  int NR    = NREG,
    localparam int IDX_W = $clog2(NR)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 core_a_valid,
    input  logic [DATA_W-1:0]    core_a_result,
    input  logic                 core_b_valid,
    input  logic [DATA_W-1:0]    core_b_result,
    input  logic [NR*DATA_W-1:0] arch_regs,
    input  logic                 vis_req,
    output logic                 vis_grant,
    output logic                 commit_pulse,
    output logic                 rollback_pulse,
    output logic                 restore_valid,
    output logic [IDX_W-1:0]     restore_idx,
    output logic [DATA_W-1:0]    restore_data
);

    logic              rv [NCORE];
    logic [DATA_W-1:0] rd [NCORE];
    sig_state_t        st [NCORE];
    logic              restoring;
    logic              cmp_ready;
    logic              sig_equal;
    logic              do_commit;
    logic              do_rollback;

    assign rv[0] = core_a_valid;
    assign rd[0] = core_a_result;
    assign rv[1] = core_b_valid;
    assign rd[1] = core_b_result;

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        fp_sig_unit u_sig (
            .clk       (clk),
            .rst       (rst),
            .ret_valid (rv[c]),
            .ret_data  (rd[c]),
            .restart   (do_commit),
            .discard   (do_rollback || restoring),
            .state     (st[c])
        );
    end

    // Comparison waits for equal retirement counts and an idle restore port.
    assign cmp_ready   = vis_req && !restoring && (st[0].cnt == st[1].cnt);
    assign sig_equal   = (st[0].sig == st[1].sig);
    assign do_commit   = cmp_ready && sig_equal;
    assign do_rollback = cmp_ready && !sig_equal;

    fp_snap_store #(.NR(NR)) u_snap (
        .clk     (clk),
        .rst     (rst),
        .capture (do_commit),
        .regs_in (arch_regs),
        .start   (do_rollback),
        .busy    (restoring),
        .idx     (restore_idx),
        .data    (restore_data)
    );

    assign vis_grant      = do_commit;
    assign commit_pulse   = do_commit;
    assign rollback_pulse = do_rollback;
    assign restore_valid  = restoring;

endmodule

// File: rtl/fp_ckpt_chk.sv
module fp_ckpt_chk #(
    parameter  int NR    = 8,
    localparam int IDX_W = $clog2(NR)
) (
    input logic             clk,
    input logic             rst,
    input logic             vis_req,
    input logic             vis_grant,
    input logic             commit_pulse,
    input logic             rollback_pulse,
    input logic             restore_valid,
    input logic [IDX_W-1:0] restore_idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NR - 1);

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(commit_pulse && rollback_pulse));                                  // R12
    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        vis_grant |-> vis_req);                                              // R12
    AST_RESTORE_BEGIN: assert property (@(posedge clk) disable iff (rst)
        rollback_pulse |=> (restore_valid && restore_idx == '0));            // R6
    AST_RESTORE_STEP: assert property (@(posedge clk) disable iff (rst)
        (restore_valid && restore_idx != LAST) |=>
            (restore_valid && restore_idx == IDX_W'($past(restore_idx) + 1'b1))); // R6
    AST_RESTORE_END: assert property (@(posedge clk) disable iff (rst)
        (restore_valid && restore_idx == LAST) |=> !restore_valid);          // R6
    AST_QUIET_IN_RESTORE: assert property (@(posedge clk) disable iff (rst)
        restore_valid |-> (!vis_grant && !commit_pulse && !rollback_pulse)); // R9

endmodule

bind fp_ckpt_ctrl fp_ckpt_chk #(.NR(NR)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .vis_req        (vis_req),
    .vis_grant      (vis_grant),
    .commit_pulse   (commit_pulse),
    .rollback_pulse (rollback_pulse),
    .restore_valid  (restore_valid),
    .restore_idx    (restore_idx)
);

// File: tb/fp_ckpt_ctrl_test.sv
module fp_ckpt_ctrl_test;

    localparam int NRG = 8;
    localparam int DW  = 32;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           a_v = 1'b0, b_v = 1'b0, req = 1'b0;
    logic [DW-1:0]  a_d = '0, b_d = '0;
    logic [NRG*DW-1:0] regs;
    logic           grant, cpulse, rpulse, rvalid;
    logic [2:0]     ridx;
    logic [DW-1:0]  rdata;

    int total = 0;
    int bad   = 0;
    int epoch = 0;
    bit ended = 0;

    logic [15:0] m_sig [2];
    int          m_cnt [2];
    logic [DW-1:0] m_snap [NRG];

    always #5 clk = ~clk;

    always_comb
        for (int i = 0; i < NRG; i++)
            regs[i*DW +: DW] = 32'hC0DE_0000 + DW'(epoch * 256 + i);

    fp_ckpt_ctrl uut (
        .clk(clk), .rst(rst),
        .core_a_valid(a_v), .core_a_result(a_d),
        .core_b_valid(b_v), .core_b_result(b_d),
        .arch_regs(regs), .vis_req(req), .vis_grant(grant),
        .commit_pulse(cpulse), .rollback_pulse(rpulse),
        .restore_valid(rvalid), .restore_idx(ridx), .restore_data(rdata)
    );

    // Reference signature: shift the word out msb first.
    function automatic logic [15:0] ref_crc(input logic [15:0] s, input logic [31:0] d);
        logic [15:0] r = s;
        logic [31:0] w = d;
        for (int k = 0; k < 32; k++) begin
            r = {r[14:0], 1'b0} ^ ({16{r[15] ^ w[31]}} & 16'h1021);
            w = w << 1;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic seed_model();
        for (int c = 0; c < 2; c++) begin
            m_sig[c] = 16'hFFFF;
            m_cnt[c] = 0;
        end
    endtask

    task automatic fold(input int c, input logic [31:0] d);
        m_sig[c] = ref_crc(m_sig[c], d);
        m_cnt[c]++;
    endtask

    task automatic retire(input bit av, input logic [31:0] ad, input bit bv, input logic [31:0] bd);
        a_v = av; a_d = ad; b_v = bv; b_d = bd;
        @(negedge clk);
        check("R2 no pulse while retiring", {30'd0, cpulse, rpulse}, 32'd0);
        if (av) fold(0, ad);
        if (bv) fold(1, bd);
        tick();
        a_v = 0; b_v = 0;
    endtask

    task automatic restore_check(input string tag, input bit noise);
        for (int k = 0; k < NRG; k++) begin
            if (noise) begin
                a_v = 1; a_d = 32'hBAD0_0000 + k; req = 1;
            end
            @(negedge clk);
            check({tag, " R6 valid"}, {31'd0, rvalid}, 32'd1);
            check({tag, " R6 idx"}, {29'd0, ridx}, k);
            check({tag, " R4/R7 data"}, rdata, m_snap[k]);
            if (noise)
                check({tag, " R9 quiet"}, {29'd0, grant, cpulse, rpulse}, 32'd0);
            tick();
        end
        a_v = 0; req = 0;
        @(negedge clk);
        check({tag, " R6 end"}, {31'd0, rvalid}, 32'd0);
        tick();
    endtask

    task automatic request(input string tag, input bit av, input logic [31:0] ad,
                           input bit bv, input logic [31:0] bd);
        bit ready, ec, er;
        a_v = av; a_d = ad; b_v = bv; b_d = bd; req = 1;
        @(negedge clk);
        ready = (m_cnt[0] == m_cnt[1]);
        ec = ready && (m_sig[0] == m_sig[1]);
        er = ready && (m_sig[0] != m_sig[1]);
        check({tag, " R3 grant"}, {31'd0, grant}, {31'd0, ec});
        check({tag, " R3 commit"}, {31'd0, cpulse}, {31'd0, ec});
        check({tag, " R5 rollback"}, {31'd0, rpulse}, {31'd0, er});
        check({tag, " R12 exclusive"}, {31'd0, cpulse & rpulse}, 32'd0);
        if (ec) begin
            for (int i = 0; i < NRG; i++) m_snap[i] = regs[i*DW +: DW];
            seed_model();
            if (av) fold(0, ad);
            if (bv) fold(1, bd);
        end else if (er) begin
            seed_model();
        end else begin
            if (av) fold(0, ad);
            if (bv) fold(1, bd);
        end
        tick();
        a_v = 0; b_v = 0; req = 0;
        if (er) restore_check(tag, 0);
    endtask

    // kind: 0 both retire, 1 core A only, 2 core B only, 3 request
    localparam int NV = 15;
    localparam logic [65:0] VEC [NV] = '{
        {2'd0, 32'h1111_1111, 32'h1111_1111},
        {2'd0, 32'h2222_2222, 32'h2222_2222},
        {2'd3, 32'h0,         32'h0},
        {2'd0, 32'h1234_5678, 32'h1234_5678},
        {2'd0, 32'h0000_0000, 32'h0000_0001},
        {2'd3, 32'h0,         32'h0},
        {2'd1, 32'hDEAD_BEEF, 32'h0},
        {2'd3, 32'h0,         32'h0},
        {2'd2, 32'h0,         32'hDEAD_BEEF},
        {2'd3, 32'h0,         32'h0},
        {2'd0, 32'hAAAA_0000, 32'h0000_AAAA},
        {2'd3, 32'h0,         32'h0},
        {2'd0, 32'h0000_0005, 32'h0000_0006},
        {2'd0, 32'h0000_0006, 32'h0000_0005},
        {2'd3, 32'h0,         32'h0}
    };

    function automatic string row_tag(input int i);
        case (i)
            7:  return "R2 count hold";
            11: return "R7 first rollback";
            14: return "R1 reorder / R7 second rollback";
            default: return "table";
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        seed_model();
        for (int i = 0; i < NRG; i++) m_snap[i] = '0;
        rst = 1;
        tick(); tick();
        @(negedge clk);
        check("R11 reset outputs", {28'd0, grant, cpulse, rpulse, rvalid}, 32'd0);
        rst = 0;
        tick();

        // R11: rollback straight after reset restores an all-zero snapshot
        retire(1, 32'h1, 1, 32'h2);
        request("R11 zero snapshot", 0, 0, 0, 0);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][65:64])
                2'd0: retire(1, VEC[i][63:32], 1, VEC[i][31:0]);
                2'd1: retire(1, VEC[i][63:32], 0, 0);
                2'd2: retire(0, 0, 1, VEC[i][31:0]);
                default: begin
                    epoch++;
                    request(row_tag(i), 0, 0, 0, 0);
                end
            endcase
        end

        // R10: words retired in the commit cycle open the new interval
        epoch++;
        retire(1, 32'h7, 1, 32'h7);
        request("R10 commit with retire", 1, 32'h8, 1, 32'h9);
        request("R10 next interval", 0, 0, 0, 0);

        // R9/R8: retire in rollback cycle and during restore is discarded
        epoch++;
        retire(1, 32'h3, 1, 32'h4);
        a_v = 1; a_d = 32'h55; b_v = 1; b_d = 32'h66; req = 1;
        @(negedge clk);
        check("R9 rollback cycle", {31'd0, rpulse}, 32'd1);
        seed_model();
        tick();
        b_v = 0;
        restore_check("R9 noisy restore", 1);
        retire(1, 32'h9, 1, 32'h9);
        epoch++;
        request("R8 R9 restart after rollback", 0, 0, 0, 0);

        ended = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule